// File: doc/BRIEF.md
# Ultra-low-power wakeup detector

This block watches three slow board-level inputs (AC adapter present, lid open and power button) while the rest of the chip sleeps. Each input passes through its own debounce filter, clocked by a sample-tick enable, with a separately programmed threshold. Glitches shorter than the programmed window are removed.

When the feature is enabled, a filtered wake condition latches a sticky wakeup event. A filtered high on AC present or lid open is a wake condition. A filtered change of the power button to its pressed level is also a wake condition. The event can be read through a small register port and drives the wakeup output pin. Software acknowledges the event by writing 1 to the status bit.

The register port is a flat word-addressed bus with a write strobe and a combinational read. Address 0 holds the enable in bit 0. Addresses 1, 2 and 3 hold the AC, lid and power-button thresholds in the low CNT_W bits. Address 4 holds the event in bit 0.

Top module: `ulp_wake_detect`

## Requirements
- R1: After reset the enable is 0, the event bit and `wake_o` are 0, and every threshold reads back as RST_CNT (default 4).
- R2: Writes take effect on the clock edge that carries `reg_we_i`. Reads are combinational: enable at address 0 bit 0, AC/lid/button thresholds at addresses 1/2/3 (low CNT_W bits), event at address 4 bit 0. Unused addresses and bits read 0.
- R3: A filter samples its input only on cycles with `tick_i` high. Its output takes a new level on the tick whose sample completes a run of max(T,1) consecutive equal samples, where T is that input's threshold. A sample equal to the current output leaves the output unchanged.
- R4: A pulse on lid open that lasts fewer samples than the lid threshold records no event.
- R5: A lid-open level of 1 held through the debounce window sets the event bit one cycle after the filter output rises. `wake_o` equals the event bit.
- R6: AC present is handled like lid open: a debounced high sets the event.
- R7: The power button (pressed level 1 by default, parameter PWRB_PRESS_LVL) sets the event only on the debounced change to pressed. Holding it pressed after an acknowledge, or releasing it, records nothing.
- R8: While the enable is 0, no event is recorded and all filters return to the inactive level with cleared counts. An event already latched stays set. After re-enabling, a full debounce window is needed again.
- R9: Writing 1 to address 4 bit 0 clears the event, and writing 0 there leaves it unchanged. A wake condition present in the same cycle wins, so a level still held on AC or lid re-sets the event.
- R10: With all three inputs held at their inactive level and the feature enabled, no event is ever recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable for the debounce filters |
| ac_present_i | input | 1 | AC adapter present, active high |
| lid_open_i | input | 1 | Lid open, active high |
| pwr_btn_i | input | 1 | Power button raw level |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| wake_o | output | 1 | Wakeup pin, follows the event bit |

## Verification
The assertions assume the raw inputs and the register port are held steady around the clock edge. The bench meets this by driving every input on the falling edge. The filter assertions also assume that `tick_i` is the only qualifier of sampling and that the enable comes from the register alone. The stimulus therefore runs a free tick at half the clock rate through all phases, including reset and the disabled window.

Glitch widths are chosen as a number of cycles that spans fewer ticks than the threshold in use. The disabled window is long enough that a filter left running would have fired.

// File: rtl/ulp_wake_pkg.sv
package ulp_wake_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_AC   = 0;
  localparam int SRC_LID  = 1;
  localparam int SRC_PWRB = 2;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL     = 3'd0,
    ADDR_AC_THR   = 3'd1,
    ADDR_LID_THR  = 3'd2,
    ADDR_PWRB_THR = 3'd3,
    ADDR_STATUS   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ulp_debounce.sv
module ulp_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             filt_o,
  output logic             rise_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             cand_q, filt_q, rise_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, need;
  logic             done;

  always_comb begin
    need = (thr_i == '0) ? CNT_ONE : thr_i;
    if (raw_i == cand_q) cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    else                 cnt_nxt = CNT_ONE;
    done = (raw_i != filt_q) && (cnt_nxt >= need);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= 1'b0;
      filt_q <= 1'b0;
      rise_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      cand_q <= 1'b0;
      filt_q <= 1'b0;
      rise_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      cand_q <= raw_i;
      cnt_q  <= cnt_nxt;
      rise_q <= done && raw_i;
      if (done) filt_q <= raw_i;
    end else begin
      rise_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;
  assign rise_o = rise_q;

  // R3: sampling happens only on ticks
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(filt_q));
  // R3: a sample equal to the output never moves it
  a_r3_match_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && (raw_i == filt_q)) |=> $stable(filt_q));
  // R8: disabled filter sits at the inactive level
  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!filt_q && !rise_q && cnt_q == '0));
endmodule

// File: rtl/ulp_wake_regs.sv
module ulp_wake_regs
  import ulp_wake_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_CNT = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic                            set_i,
  output logic                            en_o,
  output logic [NUM_SRC-1:0][CNT_W-1:0]   thr_o,
  output logic                            status_o
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(RST_CNT);

  logic                          en_q, status_q, clr;
  logic [NUM_SRC-1:0][CNT_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      en_q <= 1'b0;
    else if (we_i && addr_i == ADDR_W'(ADDR_CTRL))    en_q <= wdata_i[0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              thr_q[g] <= THR_RST;
      else if (we_i && addr_i == ADDR_W'(int'(ADDR_AC_THR) + g)) thr_q[g] <= wdata_i[CNT_W-1:0];
    end
  end

  assign clr = we_i && (addr_i == ADDR_W'(ADDR_STATUS)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= (status_q && !clr) || set_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))   rdata_o[0] = en_q;
    if (addr_i == ADDR_W'(ADDR_STATUS)) rdata_o[0] = status_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr_i == ADDR_W'(int'(ADDR_AC_THR) + i)) rdata_o = DATA_W'(thr_q[i]);
    end
  end

  assign en_o     = en_q;
  assign thr_o    = thr_q;
  assign status_o = status_q;

  // R9: event is sticky until acknowledged
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr) |=> status_q);
  // R9: acknowledge without a pending condition clears
  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !set_i) |=> !status_q);
  // R9: a pending condition wins over the acknowledge
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_q);
endmodule

// File: rtl/ulp_wake_detect.sv
module ulp_wake_detect
  import ulp_wake_pkg::*;
#(
  parameter int   CNT_W          = 16,
  parameter int   RST_CNT        = 4,
  parameter logic PWRB_PRESS_LVL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ac_present_i,
  input  logic              lid_open_i,
  input  logic              pwr_btn_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wake_o
);
  logic                          en, status, wake_set;
  logic [NUM_SRC-1:0][CNT_W-1:0] thr;
  logic [NUM_SRC-1:0]            act, filt, rise;

  // all filters work on active-high levels
  always_comb begin
    act           = '0;
    act[SRC_AC]   = ac_present_i;
    act[SRC_LID]  = lid_open_i;
    act[SRC_PWRB] = (pwr_btn_i == PWRB_PRESS_LVL);
  end

  ulp_wake_regs #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .set_i    (wake_set),
    .en_o     (en),
    .thr_o    (thr),
    .status_o (status)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_deb
    ulp_debounce #(.CNT_W(CNT_W)) i_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .tick_i (tick_i),
      .raw_i  (act[g]),
      .thr_i  (thr[g]),
      .filt_o (filt[g]),
      .rise_o (rise[g])
    );
  end

  // level wake for AC and lid, edge wake for the button
  assign wake_set = en && (filt[SRC_AC] || filt[SRC_LID] || rise[SRC_PWRB]);
  assign wake_o   = status;

  // R8: nothing is latched while disabled
  a_r8_no_set_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !status && !wake_set) |=> !wake_o);
  // R7: a button event needs a filter edge, not a held level
  a_r7_button_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[SRC_PWRB] |=> !rise[SRC_PWRB]);
endmodule

// File: tb/test_ulp_wake_detect.sv
module test_ulp_wake_detect;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        ac = 1'b0, lid = 1'b0, pwr = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        wake;
  int nchk = 0, nfail = 0;
  bit started = 0, finished = 0;

  always #10 clk = ~clk;

  ulp_wake_detect i_ulp_wake_detect (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ac_present_i(ac),
    .lid_open_i(lid), .pwr_btn_i(pwr), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_o(wake));

  always @(negedge clk) tick <= ~tick;

  // behavioural reference model
  int m_last[3], m_run[3], m_thr[3];
  bit m_filt[3], m_pulse, m_en, m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_last[i] = 0; m_run[i] = 0; m_thr[i] = 4; m_filt[i] = 0;
      end
      m_pulse = 0; m_en = 0; m_stat = 0;
    end else begin
      bit set, np;
      int a[3];
      int need;
      a[0] = int'(ac); a[1] = int'(lid); a[2] = int'(pwr);
      set = m_en && (m_filt[0] || m_filt[1] || m_pulse);
      if (we && addr == 3'd4 && wdata[0]) m_stat = 0;
      if (set) m_stat = 1;
      np = 0;
      for (int i = 0; i < 3; i++) begin
        if (!m_en) begin
          m_last[i] = 0; m_run[i] = 0; m_filt[i] = 0;
        end else if (tick) begin
          m_run[i] = (a[i] == m_last[i]) ? m_run[i] + 1 : 1;
          m_last[i] = a[i];
          need = (m_thr[i] == 0) ? 1 : m_thr[i];
          if (a[i] != int'(m_filt[i]) && m_run[i] >= need) begin
            m_filt[i] = a[i][0];
            if (i == 2 && a[i] == 1) np = 1;
          end
        end
      end
      m_pulse = np;
      if (we) begin
        if (addr == 3'd0) m_en = wdata[0];
        if (addr >= 3'd1 && addr <= 3'd3) m_thr[addr - 1] = int'(wdata[15:0]);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && started) chk({31'b0, wake}, {31'b0, m_stat}, "R5 per-cycle wake vs model");

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    #2 chk(rdata, exp, tag);
  endtask

  initial begin
    cyc(4); rst_n = 1'b1; started = 1;
    // R1
    #2 chk({31'b0, wake}, 32'd0, "R1 wake after reset");
    rd(3'd0, 32'd0, "R1 enable reset");
    rd(3'd1, 32'd4, "R1 ac threshold reset");
    rd(3'd3, 32'd4, "R1 button threshold reset");
    rd(3'd4, 32'd0, "R1 event reset");
    // R2
    wr(3'd1, 32'hffff_0005); wr(3'd2, 32'd6); wr(3'd3, 32'd4);
    rd(3'd1, 32'd5, "R2 ac threshold readback");
    rd(3'd2, 32'd6, "R2 lid threshold readback");
    rd(3'd7, 32'd0, "R2 unused address");
    wr(3'd0, 32'd1);
    rd(3'd0, 32'd1, "R2 enable readback");
    // R10
    cyc(300);
    rd(3'd4, 32'd0, "R10 idle inputs give no event");
    // R4
    @(negedge clk); lid = 1'b1; cyc(4); lid = 1'b0; cyc(50);
    chk({31'b0, wake}, 32'd0, "R4 lid glitch ignored");
    // R5
    lid = 1'b1; cyc(40);
    chk({31'b0, wake}, 32'd1, "R5 lid wake");
    rd(3'd4, 32'd1, "R5 event bit");
    // R9
    wr(3'd4, 32'd1); cyc(1);
    chk({31'b0, wake}, 32'd1, "R9 held lid re-sets event");
    lid = 1'b0; cyc(30); wr(3'd4, 32'd1); cyc(2);
    chk({31'b0, wake}, 32'd0, "R9 acknowledge clears");
    // R6
    ac = 1'b1; cyc(30);
    chk({31'b0, wake}, 32'd1, "R6 ac wake");
    ac = 1'b0; cyc(30); wr(3'd4, 32'd1); cyc(2);
    chk({31'b0, wake}, 32'd0, "R6 clear after ac low");
    // R7
    pwr = 1'b1; cyc(30);
    chk({31'b0, wake}, 32'd1, "R7 button press wake");
    wr(3'd4, 32'd1); cyc(20);
    chk({31'b0, wake}, 32'd0, "R7 held press no re-set");
    pwr = 1'b0; cyc(30);
    chk({31'b0, wake}, 32'd0, "R7 release no wake");
    // R8
    lid = 1'b1; cyc(40);
    chk({31'b0, wake}, 32'd1, "R8 wake before disable");
    wr(3'd0, 32'd0); cyc(3);
    chk({31'b0, wake}, 32'd1, "R8 latched event kept when disabled");
    wr(3'd4, 32'd1); cyc(60);
    chk({31'b0, wake}, 32'd0, "R8 no event while disabled");
    wr(3'd0, 32'd1); cyc(2);
    chk({31'b0, wake}, 32'd0, "R8 window restarts after enable");
    cyc(40);
    chk({31'b0, wake}, 32'd1, "R8 wake after re-enable");
    wr(3'd4, 32'd0); cyc(2);
    chk({31'b0, wake}, 32'd1, "R9 writing 0 keeps event");
    // R3 threshold 0 acts as 1
    wr(3'd2, 32'd0); lid = 1'b0; cyc(6); wr(3'd4, 32'd1); cyc(2);
    chk({31'b0, wake}, 32'd0, "R3 zero threshold filter drop");
    @(negedge clk); lid = 1'b1; cyc(2); lid = 1'b0; cyc(3);
    chk({31'b0, wake}, 32'd1, "R3 zero threshold single sample");
    cyc(5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule